// File: doc/BRIEF.md
# Stereo Volume and Peak Monitor

This block applies a per-channel linear attenuation to a stream of stereo 24-bit two's-complement audio samples and keeps, for each channel, a running record of the largest output magnitude seen since that record was last read. A source presents a left/right pair with a one-cycle strobe; the block scales both words by the channel's current volume code and returns them with a one-cycle output strobe two cycles later. Software-side logic writes volume codes through a small write port and collects peak levels through a read strobe per channel, and each read clears the record.

A three-state sequencer paces each sample. In `ST_IDLE` it waits for a strobe; the transition *accept* (strobe seen in `ST_IDLE`) captures both samples and latches the pending volume codes into the active codes, moving to `ST_SCALE`. The transition *compute* (unconditional) registers the scaled words and moves to `ST_EMIT`. In `ST_EMIT` the output strobe is high and the transition *retire* (unconditional) updates both peak records and returns to `ST_IDLE`. Strobes seen in `ST_SCALE` or `ST_EMIT` are dropped, so samples must be at least three cycles apart, which any audio-rate source meets by a wide margin.

Top module: `stereo_vol_peak`

## Requirements
- R1: After reset both outputs are zero, the output strobe is low, both peak records read zero, and both volume codes are 0 (unity gain).
- R2: With an 8-bit volume code N, an output word equals the input word times (256 − N) / 256 with the quotient truncated toward zero; code 0 returns the input unchanged.
- R3: The two channels use separate volume codes; a write with the channel select at 0 sets the left code and at 1 sets the right code, without disturbing the other channel.
- R4: A strobe presented in an idle cycle produces an output strobe that is high for exactly one cycle, two cycles after the strobe cycle, carrying the scaled words of that pair.
- R5: A strobe presented in either of the two cycles after an accepted strobe is ignored: it yields no output strobe and does not reach the peak records.
- R6: A volume write takes effect for the first strobe accepted in a later cycle; a write in the same cycle as an accepted strobe, or while that sample is in flight, does not change that sample's result.
- R7: Each peak record holds the largest absolute value of that channel's output words since reset or since its last read, updated at the end of the output strobe cycle.
- R8: The most negative word (−8388608) counts as magnitude 8388607 in the peak record.
- R9: A read strobe returns the record on the peak output in that cycle and clears it to zero at the next edge; if the read coincides with the output strobe, the record is loaded with the new output's magnitude instead of zero.
- R10: A peak record never changes in a cycle without its read strobe or the output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 24 | Left input sample, two's complement |
| smp_right | input | 24 | Right input sample, two's complement |
| vol_wr | input | 1 | Volume code write strobe |
| vol_ch | input | 1 | Volume channel select: 0 left, 1 right |
| vol_code | input | 8 | Volume code, 0 = unity, 255 = 1/256 |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| pk_rd_left | input | 1 | Read-and-clear strobe for left peak |
| pk_rd_right | input | 1 | Read-and-clear strobe for right peak |
| pk_left | output | 23 | Left peak magnitude |
| pk_right | output | 23 | Right peak magnitude |

## Verification
The assertions watch every cycle for the sequencer's fixed walk from `ST_SCALE` through `ST_EMIT`, the single-cycle output strobe and its tie to a strobe two cycles earlier, peak records that move only on a read or a retire, clearing after a lone read, and a record that never sits below the magnitude it just absorbed. The arithmetic of the attenuation over all 256 codes, truncation toward zero on negative words, the saturated magnitude of the most negative word, the timing of volume writes against in-flight samples, dropped strobes and the read colliding with an update are shown only by the bench's scenarios against values it computes itself.

// File: rtl/svp_pkg.sv
`timescale 1ns/1ps
package svp_pkg;
    localparam int NCH = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCALE = 2'd1,
        ST_EMIT  = 2'd2
    } svp_state_e;
endpackage

// File: rtl/svp_scaler.sv
`timescale 1ns/1ps
module svp_scaler #(
    parameter int SW = 24,
    parameter int VW = 8
) (
    input  logic signed [SW-1:0] smp_i,
    input  logic        [VW-1:0] code_i,
    output logic signed [SW-1:0] res_o
);
    localparam int GW = VW + 1;
    localparam int PW = SW + GW + 1;

    logic        [GW-1:0] gain;
    logic signed [PW-1:0] s_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] bias;
    logic signed [PW-1:0] sum;

    always_comb begin
        // unity weight is 2**VW; each code step removes one part in 2**VW
        gain  = GW'(1 << VW) - {1'b0, code_i};
        s_ext = PW'(smp_i);
        g_ext = PW'(gain);
        prod  = s_ext * g_ext;
        // negative products are biased so the arithmetic shift truncates toward zero
        bias  = prod[PW-1] ? PW'((1 << VW) - 1) : '0;
        sum   = prod + bias;
        res_o = SW'(sum >>> VW);
    end
endmodule

// File: rtl/svp_peak.sv
`timescale 1ns/1ps
module svp_peak #(
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  logic signed [SW-1:0] smp_i,
    input  logic                 rd_i,
    output logic        [SW-2:0] pk_o
);
    localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

    logic [SW-2:0] mag;
    logic [SW-2:0] pk_q;

    always_comb begin
        if (smp_i == MOST_NEG) begin
            mag = '1;
        end else if (smp_i[SW-1]) begin
            mag = (SW-1)'(-smp_i);
        end else begin
            mag = smp_i[SW-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else if (rd_i && upd_i) begin
            pk_q <= mag;
        end else if (rd_i) begin
            pk_q <= '0;
        end else if (upd_i && (mag > pk_q)) begin
            pk_q <= mag;
        end
    end

    assign pk_o = pk_q;
endmodule

// File: rtl/svp_ctrl.sv
`timescale 1ns/1ps
module svp_ctrl
    import svp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    output logic       cap_o,
    output logic       res_o,
    output logic       emit_o,
    output svp_state_e state_o
);
    svp_state_e state_q;
    svp_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cap_o   = 1'b0;
        res_o   = 1'b0;
        emit_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_i) begin
                    cap_o   = 1'b1;
                    state_d = ST_SCALE;
                end
            end
            ST_SCALE: begin
                res_o   = 1'b1;
                state_d = ST_EMIT;
            end
            ST_EMIT: begin
                emit_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/stereo_vol_peak.sv
`timescale 1ns/1ps
module stereo_vol_peak
    import svp_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int VOL_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                vol_wr,
    input  logic                vol_ch,
    input  logic [VOL_W-1:0]    vol_code,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    input  logic                pk_rd_left,
    input  logic                pk_rd_right,
    output logic [SAMPLE_W-2:0] pk_left,
    output logic [SAMPLE_W-2:0] pk_right
);
    logic       cap_en;
    logic       res_en;
    logic       emit;
    svp_state_e fsm_state;

    logic signed [SAMPLE_W-1:0] smp_in   [NCH];
    logic                       rd_in    [NCH];
    logic signed [SAMPLE_W-1:0] smp_q    [NCH];
    logic        [VOL_W-1:0]    vol_pend [NCH];
    logic        [VOL_W-1:0]    vol_act  [NCH];
    logic signed [SAMPLE_W-1:0] scaled   [NCH];
    logic signed [SAMPLE_W-1:0] scaled_q [NCH];
    logic        [SAMPLE_W-2:0] pk       [NCH];

    assign smp_in[0] = smp_left;
    assign smp_in[1] = smp_right;
    assign rd_in[0]  = pk_rd_left;
    assign rd_in[1]  = pk_rd_right;

    svp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (smp_valid),
        .cap_o    (cap_en),
        .res_o    (res_en),
        .emit_o   (emit),
        .state_o  (fsm_state)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // pending code: written any time, sampled only when a strobe is accepted
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vol_pend[c] <= '0;
            end else if (vol_wr && (vol_ch == 1'(c))) begin
                vol_pend[c] <= vol_code;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q[c]   <= '0;
                vol_act[c] <= '0;
            end else if (cap_en) begin
                smp_q[c]   <= smp_in[c];
                vol_act[c] <= vol_pend[c];
            end
        end

        svp_scaler #(
            .SW (SAMPLE_W),
            .VW (VOL_W)
        ) u_scale (
            .smp_i  (smp_q[c]),
            .code_i (vol_act[c]),
            .res_o  (scaled[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scaled_q[c] <= '0;
            end else if (res_en) begin
                scaled_q[c] <= scaled[c];
            end
        end

        svp_peak #(
            .SW (SAMPLE_W)
        ) u_peak (
            .clk   (clk),
            .rst_n (rst_n),
            .upd_i (emit),
            .smp_i (scaled_q[c]),
            .rd_i  (rd_in[c]),
            .pk_o  (pk[c])
        );
    end

    assign out_valid = emit;
    assign out_left  = scaled_q[0];
    assign out_right = scaled_q[1];
    assign pk_left   = pk[0];
    assign pk_right  = pk[1];
endmodule

// File: rtl/svp_chk.sv
`timescale 1ns/1ps
module svp_chk
    import svp_pkg::*;
#(
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          out_valid,
    input logic [SW-1:0] out_left,
    input logic [SW-1:0] out_right,
    input logic          pk_rd_left,
    input logic          pk_rd_right,
    input logic [SW-2:0] pk_left,
    input logic [SW-2:0] pk_right,
    input svp_state_e    fsm_state
);
    function automatic logic [SW-2:0] mag_of(input logic [SW-1:0] v);
        if (v == {1'b1, {(SW-1){1'b0}}}) return '1;
        if (v[SW-1]) return (SW-1)'(-v);
        return v[SW-2:0];
    endfunction

    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid, 2));

    // R5
    scale_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SCALE) |=> (fsm_state == ST_EMIT));

    // R5
    emit_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EMIT) |=> (fsm_state == ST_IDLE));

    // R10
    pk_hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pk_rd_left) && !$past(out_valid)) |-> $stable(pk_left));

    // R10
    pk_hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pk_rd_right) && !$past(out_valid)) |-> $stable(pk_right));

    // R9
    pk_clr_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pk_rd_left) && !$past(out_valid)) |-> (pk_left == '0));

    // R9
    pk_clr_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pk_rd_right) && !$past(out_valid)) |-> (pk_right == '0));

    // R7
    pk_cover_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_valid) |-> (pk_left >= mag_of($past(out_left))));

    // R7
    pk_cover_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_valid) |-> (pk_right >= mag_of($past(out_right))));
endmodule

bind stereo_vol_peak svp_chk #(.SW(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .out_valid   (out_valid),
    .out_left    (out_left),
    .out_right   (out_right),
    .pk_rd_left  (pk_rd_left),
    .pk_rd_right (pk_rd_right),
    .pk_left     (pk_left),
    .pk_right    (pk_right),
    .fsm_state   (fsm_state)
);

// File: tb/sim_stereo_vol_peak.sv
`timescale 1ns/1ps
module sim_stereo_vol_peak;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        vol_wr = 1'b0;
    logic        vol_ch = 1'b0;
    logic [7:0]  vol_code = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        pk_rd_left = 1'b0;
    logic        pk_rd_right = 1'b0;
    logic [22:0] pk_left;
    logic [22:0] pk_right;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  vol_m [2];
    longint pk_m [2];
    int  seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    stereo_vol_peak u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .vol_wr(vol_wr), .vol_ch(vol_ch), .vol_code(vol_code),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .pk_rd_left(pk_rd_left), .pk_rd_right(pk_rd_right),
        .pk_left(pk_left), .pk_right(pk_right)
    );

    function automatic longint scale(input longint s, input int n);
        return (s * (256 - n)) / 256;   // SV division truncates toward zero
    endfunction

    function automatic longint mag(input longint v);
        if (v == -8388608) return 8388607;
        return (v < 0) ? -v : v;
    endfunction

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setvol(input int ch, input int code);
        vol_wr = 1'b1; vol_ch = ch[0]; vol_code = code[7:0];
        @(negedge clk);
        vol_wr = 1'b0;
        vol_m[ch] = code;
    endtask

    task automatic upd_pk(input longint l, input longint r);
        if (l > pk_m[0]) pk_m[0] = l;
        if (r > pk_m[1]) pk_m[1] = r;
    endtask

    task automatic run_sample(input longint l, input longint r, input string req);
        longint el, er;
        el = scale(l, vol_m[0]);
        er = scale(r, vol_m[1]);
        smp_valid = 1'b1; smp_left = 24'(l); smp_right = 24'(r);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk({req, " strobe"}, out_valid, 1);
        chk({req, " left"}, sx(out_left), el);
        chk({req, " right"}, sx(out_right), er);
        @(negedge clk);
        upd_pk(mag(el), mag(er));
        chk("R4 strobe width", out_valid, 0);
        chk("R7 left peak", pk_left, pk_m[0]);
        chk("R7 right peak", pk_right, pk_m[1]);
    endtask

    task automatic read_both();
        pk_rd_left = 1'b1; pk_rd_right = 1'b1;
        chk("R9 left read value", pk_left, pk_m[0]);
        chk("R9 right read value", pk_right, pk_m[1]);
        @(negedge clk);
        pk_rd_left = 1'b0; pk_rd_right = 1'b0;
        pk_m[0] = 0; pk_m[1] = 0;
        chk("R9 left cleared", pk_left, 0);
        chk("R9 right cleared", pk_right, 0);
    endtask

    function automatic longint next_rand();
        logic [23:0] t;
        seed = seed * 1103515245 + 12345;
        t = seed[30:7];
        return longint'($signed(t));
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        longint vals [4];
        vol_m[0] = 0; vol_m[1] = 0; pk_m[0] = 0; pk_m[1] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 strobe", out_valid, 0);
        chk("R1 left out", out_left, 0);
        chk("R1 right out", out_right, 0);
        chk("R1 left peak", pk_left, 0);
        chk("R1 right peak", pk_right, 0);
        run_sample(1234567, -7654321, "R1 unity after reset");

        // R8 most negative word at unity gain
        read_both();
        run_sample(-8388608, 8388607, "R8 extremes");
        chk("R8 saturated magnitude", pk_left, 8388607);
        read_both();

        // R2 R3 sweep of every code, the channels on mirrored codes
        for (int code = 0; code < 256; code++) begin
            setvol(0, code);
            setvol(1, 255 - code);
            vals[0] = 8388607;
            vals[1] = -8388608;
            vals[2] = -1;
            vals[3] = next_rand();
            for (int k = 0; k < 4; k++) begin
                run_sample(vals[k], vals[(k + 1) % 4], "R2 R3 sweep");
            end
            read_both();
        end

        // R3 writing one channel leaves the other alone
        setvol(0, 0);
        setvol(1, 0);
        setvol(1, 200);
        run_sample(-1000003, -1000003, "R3 independent codes");
        read_both();

        // R5 strobes in the two busy cycles are dropped
        setvol(0, 0);
        setvol(1, 0);
        smp_valid = 1'b1; smp_left = 24'(100); smp_right = 24'(-200);
        @(negedge clk);
        smp_left = 24'(8000000); smp_right = 24'(-8000000);
        @(negedge clk);
        chk("R5 first pair strobe", out_valid, 1);
        chk("R5 first pair left", sx(out_left), 100);
        chk("R5 first pair right", sx(out_right), -200);
        smp_left = 24'(7000000); smp_right = 24'(7000000);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R5 dropped strobe one", out_valid, 0);
        @(negedge clk);
        chk("R5 dropped strobe two", out_valid, 0);
        chk("R5 left peak", pk_left, 100);
        chk("R5 right peak", pk_right, 200);
        @(negedge clk);
        chk("R5 no late output", out_valid, 0);
        pk_m[0] = 100; pk_m[1] = 200;
        read_both();

        // R6 volume writes against a sample in flight
        smp_valid = 1'b1; smp_left = 24'(-3000001); smp_right = 24'(3000001);
        vol_wr = 1'b1; vol_ch = 1'b0; vol_code = 8'd128;
        @(negedge clk);
        smp_valid = 1'b0;
        vol_ch = 1'b1; vol_code = 8'd64;
        @(negedge clk);
        vol_wr = 1'b0;
        chk("R6 in-flight left", sx(out_left), -3000001);
        chk("R6 in-flight right", sx(out_right), 3000001);
        @(negedge clk);
        vol_m[0] = 128; vol_m[1] = 64;
        pk_m[0] = 3000001; pk_m[1] = 3000001;
        read_both();
        run_sample(-3000001, 3000001, "R6 next sample");
        read_both();

        // R9 read colliding with the output strobe
        setvol(0, 0);
        setvol(1, 0);
        run_sample(8000000, 8000000, "R9 prime");
        smp_valid = 1'b1; smp_left = 24'(-5); smp_right = 24'(7);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk("R9 collide strobe", out_valid, 1);
        chk("R9 collide read value", pk_left, 8000000);
        pk_rd_left = 1'b1;
        @(negedge clk);
        pk_rd_left = 1'b0;
        chk("R9 collide left loads new", pk_left, 5);
        chk("R10 right untouched", pk_right, 8000000);
        @(negedge clk);
        chk("R10 left held", pk_left, 5);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule